// File: doc/BRIEF.md
# Receive FIFO with byte-status tags

This block sits between the framing logic of a serial packet receiver and a processor. The framing logic has already found flags, removed stuffed bits and checked the frame check sequence. It hands over one byte per write strobe, with qualifiers that say whether the byte opens a packet, closes it, and whether the closed packet was bad. A packet is bad if its check sequence did not match or the frame was aborted. The block stores each byte together with a 2-bit position/validity tag. The processor sees the data and the tag of the head entry before it pops that entry.

The block reports its fill state as a 2-bit code against a selectable threshold of 15 or 5 bytes. When the level rises to the threshold it can raise a sticky interrupt, provided the interrupt is enabled. An attempt to write into a full store turns the receiver off. The rest of that packet is then lost. The receiver comes back on at the next frame flag, and it overflows again if the store is still full when the next byte arrives.

Top module: `rxtag_fifo`

## Requirements
- R1: The store holds 19 entries and returns bytes in the order they were written. A write accepted while fewer than 19 entries are held is stored.
- R2: The tag stored with a byte is, as (bit1,bit0): 00 for a middle byte, 01 for a first byte, 10 for the last byte of a good packet and 11 for the last byte of a bad packet. When a byte is marked last, its tag is 1 followed by the bad qualifier. Otherwise its tag is 0 followed by the first qualifier. The tag and data of the head entry appear on `rd_tag` and `rd_data` before that entry is popped.
- R3: Without an overflow, `fill_code` is 00 at 0 entries. It is 01 below the threshold and 11 at or above it. The threshold is 15 when `low_thr` is 0 and 5 when `low_thr` is 1.
- R4: A write attempt while the store is full disables the receiver. From the next cycle `fill_code` shows 10. Further writes are discarded until `flag_seen` is pulsed.
- R5: The overflow indication is held until the receiver has been re-enabled and the store holds fewer than 19 entries, even if the store has drained to empty. If a flag re-enables the receiver while the store is still full, the next write overflows again.
- R6: A write and a pop in the same cycle are both accepted when the store is neither full nor empty. A pop of an empty store changes nothing.
- R7: Reset clears the interrupt enable. The interrupt status is set, only while the enable is 1, in the cycle after the level rises from below the threshold to at or above it. It stays set until `irq_stat_rd` is pulsed, and it is not set again while the level stays above the threshold.
- R8: After reset the store is empty, `fill_code` is 00, `irq` is 0 and the receiver is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte strobe from the framing logic |
| wr_data | input | 8 | Received byte |
| wr_first | input | 1 | Byte opens a packet |
| wr_last | input | 1 | Byte closes a packet |
| wr_bad | input | 1 | Closed packet had a check mismatch or an abort |
| flag_seen | input | 1 | Pulse: a frame flag was detected |
| rd_pop | input | 1 | Processor pops the head entry |
| rd_data | output | 8 | Data of the head entry |
| rd_tag | output | 2 | Tag of the head entry |
| low_thr | input | 1 | 1 selects the 5-byte threshold |
| ien_wr | input | 1 | Write strobe for the interrupt enable |
| ien_din | input | 1 | Value written to the interrupt enable |
| irq_stat_rd | input | 1 | Processor reads the interrupt status, which clears it |
| fill_code | output | 2 | Fill-state code |
| irq | output | 1 | Sticky threshold interrupt status |

## Verification
The hardest state to reach is an overflow that persists because the receiver is re-enabled while the store is still full. Another is an overflow that outlasts a complete drain, so that the code shows 10 at zero entries. The bench fills the store to exactly 19 entries with a sweep and then forces one extra write. It interleaves pops, dropped writes and flag pulses in a fixed order, so that each release condition is met alone before both are met together. The threshold sweep checks both threshold settings at every level from 1 to 19.

// File: rtl/rxtag_pkg.sv
package rxtag_pkg;
   typedef enum logic [1:0] {
      TAG_MID      = 2'b00,
      TAG_FIRST    = 2'b01,
      TAG_LAST_OK  = 2'b10,
      TAG_LAST_BAD = 2'b11
   } tag_t;

   typedef enum logic [1:0] {
      FILL_EMPTY = 2'b00,
      FILL_LOW   = 2'b01,
      FILL_OVF   = 2'b10,
      FILL_HIGH  = 2'b11
   } fill_t;

   function automatic tag_t make_tag(input logic first, input logic last, input logic bad);
      return last ? tag_t'({1'b1, bad}) : tag_t'({1'b0, first});
   endfunction
endpackage

// File: rtl/rxtag_store.sv
module rxtag_store #(
   parameter int DEPTH  = 19,
   parameter int DATA_W = 8,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W+1:0] push_word,
   input  logic              pop,
   output logic [DATA_W+1:0] head_word,
   output logic [CW-1:0]     count,
   output logic              full,
   output logic              empty
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
   localparam logic [PW-1:0] LAST_P  = PW'(DEPTH - 1);

   logic [DATA_W+1:0] mem [DEPTH];
   logic [PW-1:0]     wp, rp, wp_nx, rp_nx;
   logic              do_push, do_pop;

   assign full    = (count == DEPTH_C);
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   generate
      if (DEPTH == (1 << PW)) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == LAST_P) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == LAST_P) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head_word = mem[rp];
endmodule

// File: rtl/rxtag_ovf.sv
module rxtag_ovf (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_valid,
   input  logic full,
   input  logic flag_seen,
   output logic rx_en,
   output logic ovf
);
   logic hit;
   assign hit = wr_valid && rx_en && full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_en <= 1'b1;
         ovf   <= 1'b0;
      end else begin
         if (hit)            rx_en <= 1'b0;
         else if (flag_seen) rx_en <= 1'b1;

         if (hit)                    ovf <= 1'b1;
         else if (rx_en && !full)    ovf <= 1'b0;
      end
   end
endmodule

// File: rtl/rxtag_level.sv
module rxtag_level
   import rxtag_pkg::*;
#(
   parameter int DEPTH    = 19,
   parameter int THR_HIGH = 15,
   parameter int THR_LOW  = 5,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count,
   input  logic          ovf,
   input  logic          low_thr,
   input  logic          ien_wr,
   input  logic          ien_din,
   input  logic          stat_rd,
   output fill_t         code,
   output logic          ien,
   output logic          irq
);
   localparam logic [CW-1:0] HI_C = CW'(THR_HIGH);
   localparam logic [CW-1:0] LO_C = CW'(THR_LOW);

   logic [CW-1:0] thr;
   logic          at_thr, at_q;

   assign thr    = low_thr ? LO_C : HI_C;
   assign at_thr = (count >= thr);

   always_comb begin
      if (ovf)                code = FILL_OVF;
      else if (count == '0)   code = FILL_EMPTY;
      else if (at_thr)        code = FILL_HIGH;
      else                    code = FILL_LOW;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien  <= 1'b0;
         at_q <= 1'b0;
         irq  <= 1'b0;
      end else begin
         if (ien_wr) ien <= ien_din;
         at_q <= at_thr;
         if (ien && at_thr && !at_q) irq <= 1'b1;
         else if (stat_rd)           irq <= 1'b0;
      end
   end
endmodule

// File: rtl/rxtag_fifo.sv
module rxtag_fifo
   import rxtag_pkg::*;
#(
   parameter int DEPTH    = 19,
   parameter int DATA_W   = 8,
   parameter int THR_HIGH = 15,
   parameter int THR_LOW  = 5,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_first,
   input  logic              wr_last,
   input  logic              wr_bad,
   input  logic              flag_seen,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        rd_tag,
   input  logic              low_thr,
   input  logic              ien_wr,
   input  logic              ien_din,
   input  logic              irq_stat_rd,
   output logic [1:0]        fill_code,
   output logic              irq
);
   generate
      if (DEPTH < 2 || THR_LOW < 1 || THR_LOW >= THR_HIGH || THR_HIGH > DEPTH) begin : g_bad_cfg
         $error("rxtag_fifo: need 1 <= THR_LOW < THR_HIGH <= DEPTH, DEPTH >= 2");
      end
      if (DATA_W < 1) begin : g_bad_w
         $error("rxtag_fifo: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W+1:0] head_word, push_word;
   logic [CW-1:0]     count;
   logic              full, empty, rx_en, ovf, ien;
   fill_t             code;

   assign push_word = {make_tag(wr_first, wr_last, wr_bad), wr_data};

   rxtag_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_valid && rx_en),
      .push_word (push_word),
      .pop       (rd_pop),
      .head_word (head_word),
      .count     (count),
      .full      (full),
      .empty     (empty)
   );

   rxtag_ovf u_ovf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (wr_valid),
      .full      (full),
      .flag_seen (flag_seen),
      .rx_en     (rx_en),
      .ovf       (ovf)
   );

   rxtag_level #(.DEPTH(DEPTH), .THR_HIGH(THR_HIGH), .THR_LOW(THR_LOW)) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .count   (count),
      .ovf     (ovf),
      .low_thr (low_thr),
      .ien_wr  (ien_wr),
      .ien_din (ien_din),
      .stat_rd (irq_stat_rd),
      .code    (code),
      .ien     (ien),
      .irq     (irq)
   );

   assign rd_data   = head_word[DATA_W-1:0];
   assign rd_tag    = head_word[DATA_W+1:DATA_W];
   assign fill_code = code;

   logic unused_empty;
   assign unused_empty = empty;
endmodule

// File: rtl/rxtag_chk.sv
module rxtag_chk #(
   parameter int DEPTH  = 19,
   parameter int DATA_W = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              rd_pop,
   input logic              irq_stat_rd,
   input logic [1:0]        fill_code,
   input logic [1:0]        rd_tag,
   input logic [DATA_W-1:0] rd_data,
   input logic              irq,
   input logic              rx_en,
   input logic              ien,
   input logic [CW-1:0]     count
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      count <= DEPTH_C);

   p_head_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_pop && count != '0) |=> ($stable(rd_tag) && $stable(rd_data)));

   p_ovf_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && rx_en && count == DEPTH_C) |=> (fill_code == 2'b10));

   p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !rd_pop) |=> (count == $past(count)));

   p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && rd_pop && !wr_valid) |=> (count == '0));

   p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_stat_rd) |=> irq);

   p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ien));
endmodule

bind rxtag_fifo rxtag_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_valid    (wr_valid),
   .rd_pop      (rd_pop),
   .irq_stat_rd (irq_stat_rd),
   .fill_code   (fill_code),
   .rd_tag      (rd_tag),
   .rd_data     (rd_data),
   .irq         (irq),
   .rx_en       (rx_en),
   .ien         (ien),
   .count       (count)
);

// File: tb/tb_rxtag_fifo.sv
`timescale 1ns/1ps
module tb_rxtag_fifo;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_valid = 0, wr_first = 0, wr_last = 0, wr_bad = 0, flag_seen = 0;
   logic [7:0] wr_data = 0;
   logic       rd_pop = 0, low_thr = 0, ien_wr = 0, ien_din = 0, irq_stat_rd = 0;
   logic [7:0] rd_data;
   logic [1:0] rd_tag, fill_code;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [7:0] qd[$];
   logic [1:0] qt[$];

   always #2.5 clk = ~clk;

   rxtag_fifo dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_first(wr_first), .wr_last(wr_last), .wr_bad(wr_bad),
      .flag_seen(flag_seen), .rd_pop(rd_pop), .rd_data(rd_data), .rd_tag(rd_tag),
      .low_thr(low_thr), .ien_wr(ien_wr), .ien_din(ien_din),
      .irq_stat_rd(irq_stat_rd), .fill_code(fill_code), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int code_of(input int n, input bit lt);
      if (n == 0) return 0;
      return (n >= (lt ? 5 : 15)) ? 3 : 1;
   endfunction

   function automatic logic [1:0] tag_of(input bit f, input bit l, input bit b);
      return l ? {1'b1, b} : {1'b0, f};
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d, input bit f, input bit l, input bit b, input bit keep);
      wr_valid = 1; wr_data = d; wr_first = f; wr_last = l; wr_bad = b;
      step();
      wr_valid = 0; wr_first = 0; wr_last = 0; wr_bad = 0;
      if (keep) begin qd.push_back(d); qt.push_back(tag_of(f, l, b)); end
   endtask

   task automatic pop_chk(input string req);
      chk({req, " head data"}, rd_data, qd[0]);
      chk({req, " head tag"}, rd_tag, qt[0]);
      rd_pop = 1; step(); rd_pop = 0;
      void'(qd.pop_front()); void'(qt.pop_front());
   endtask

   task automatic do_reset();
      rst_n = 0; step(); step(); step(); rst_n = 1; step();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #200us;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      step();
      do_reset();
      // R8 reset state
      chk("R8 fill_code", fill_code, 0);
      chk("R8 irq", irq, 0);

      ien_wr = 1; ien_din = 1; step(); ien_wr = 0;

      // R3 / R7 sweep: fill to 19, both thresholds at every level
      for (int n = 1; n <= 19; n++) begin
         wr(8'h10 + 8'(n), n == 1, n == 19, 0, 1);
         chk("R3 code high thr", fill_code, code_of(n, 0));
         low_thr = 1; #0.5;
         chk("R3 code low thr", fill_code, code_of(n, 1));
         low_thr = 0; #0.5;
         chk("R7 irq on crossing", irq, (n >= 16) ? 1 : 0);
      end

      // R4 overflow on write into full store
      wr(8'hA0, 1, 0, 0, 0);
      chk("R4 ovf code", fill_code, 2);
      wr(8'hA1, 0, 0, 0, 0);
      pop_chk("R1");
      step();
      chk("R5 held while disabled", fill_code, 2);
      wr(8'hA2, 0, 0, 0, 0);        // dropped, receiver off
      flag_seen = 1; step(); flag_seen = 0;
      chk("R5 held one cycle after flag", fill_code, 2);
      step();
      chk("R5 released below full", fill_code, 3);
      wr(8'hEE, 0, 1, 1, 1);        // accepted, store full again
      chk("R4 full code", fill_code, 3);
      wr(8'hA3, 0, 0, 0, 0);
      chk("R4 second ovf", fill_code, 2);
      flag_seen = 1; step(); flag_seen = 0;
      step();
      chk("R5 flag while full keeps ovf", fill_code, 2);
      wr(8'hA4, 1, 0, 0, 0);        // overflows again
      chk("R5 re-overflow", fill_code, 2);

      // R1 / R2 drain in order
      while (qd.size() > 0) pop_chk("R2");
      chk("R5 ovf at empty", fill_code, 2);
      chk("R7 sticky after drain", irq, 1);
      irq_stat_rd = 1; step(); irq_stat_rd = 0;
      chk("R7 cleared by read", irq, 0);
      flag_seen = 1; step(); flag_seen = 0;
      step();
      chk("R5 released at empty", fill_code, 0);

      // R6 empty pop has no effect
      rd_pop = 1; step(); rd_pop = 0;
      chk("R6 empty pop code", fill_code, 0);
      wr(8'h33, 0, 0, 0, 1);
      chk("R6 after empty pop data", rd_data, 8'h33);
      chk("R6 after empty pop code", fill_code, 1);

      // R2 all qualifier combinations, R7 low threshold crossing
      low_thr = 1;
      for (int i = 0; i < 8; i++) wr(8'h50 + 8'(i), i[0], i[1], i[2], 1);
      step();
      chk("R7 low thr irq", irq, 1);
      irq_stat_rd = 1; step(); irq_stat_rd = 0;
      step(); step();
      chk("R7 no re-set above thr", irq, 0);

      // R6 simultaneous write and pop
      for (int k = 0; k < 4; k++) begin
         chk("R6 head data", rd_data, qd[0]);
         chk("R6 head tag", rd_tag, qt[0]);
         rd_pop = 1;
         wr(8'h60 + 8'(k), 0, 0, 0, 1);
         rd_pop = 0;
         void'(qd.pop_front()); void'(qt.pop_front());
         chk("R6 level kept", fill_code, 3);
      end
      while (qd.size() > 0) pop_chk("R2");
      chk("R6 empty after drain", fill_code, 0);
      low_thr = 0;

      // R7 masked after reset
      do_reset();
      chk("R8 fill_code after reset", fill_code, 0);
      chk("R8 irq after reset", irq, 0);
      for (int n = 1; n <= 16; n++) wr(8'h80 + 8'(n), 0, 0, 0, 1);
      step();
      chk("R7 masked after reset", irq, 0);
      ien_wr = 1; ien_din = 1; step(); ien_wr = 0;
      step();
      chk("R7 no crossing after enable", irq, 0);
      while (qd.size() > 0) pop_chk("R1");

      finish_run();
   end
endmodule